// File: doc/BRIEF.md
# Indexed Address Generation Sequencer

This block steps through the bus cycles of an 8-bit CPU's indexed memory access. It handles two address shapes. In the absolute shape, two operand bytes give a base address and an index value is added to it. In the zero-page-indirect shape, one operand byte names a pointer in page zero, and the index is added to that pointer. The surrounding core pulses `start` with the mode, the index register value, a store flag, the store data and the program counter of the opcode. The sequencer then drives one bus access per clock, starting with the opcode fetch.

The low byte of the effective address comes from an 8-bit adder. That add overlaps the fetch of the high address byte. When the add carries out, the first access goes to the partially added address (old high byte, new low byte). That access is a dummy read, and the high byte is then incremented for a second access. Stores always spend that second cycle, carry or not: the dummy read comes first, then the write at the corrected address. On completion the block pulses `done` and presents the data read, the number of bus cycles used and the advanced program counter.

Top module: `idx_seq`

## Requirements
- R1: After synchronous reset, `done`, `mem_we`, `cycles`, `rdata`, `mem_addr` and `pc_out` are all zero.
- R2: An absolute-mode load whose low-byte add does not carry uses 4 bus cycles. The reads go to pc, pc+1 (low byte), pc+2 (high byte), then {high, low+index}. `rdata` returns the byte read in the last cycle.
- R3: A load whose low-byte add carries spends one more cycle. It first reads {high, low+index mod 256} and then reads {high+1, low+index mod 256}, so an absolute load takes 5 cycles. The data of the second read is returned.
- R4: A store always takes the extra cycle. It reads at {high, low+index} with `mem_we` low, then writes `wdata` at {high+carry, low+index} with `mem_we` high. An absolute store takes 5 cycles and an indirect store takes 6. `rdata` keeps its previous value.
- R5: In indirect mode the operand byte p is read at pc+1. The pointer low and high bytes are then read at {0x00,p} and {0x00,(p+1) mod 256}, so 0xFF wraps to 0x00. The index is added to that pointer, giving 5 cycles for a load without carry and 6 for a load with carry.
- R6: `mode[1]`=0 selects absolute and `mode[1]`=1 selects indirect. `mode[0]` (X versus Y naming) has no effect on the sequence.
- R7: `done` is a one-cycle pulse, high in the clock after the last bus cycle. While it is high, `cycles` holds the bus-cycle count (the opcode fetch counted as 1), and `pc_out` holds pc+3 for absolute or pc+2 for indirect, modulo 2^16.
- R8: A `start` pulse that arrives while a sequence is running is ignored. The running sequence's bus trace and results are unchanged.
- R9: `mem_we` is high only in the single write cycle of a store, and `mem_wdata` equals the store data in that cycle.
- R10: Address arithmetic wraps at 16 bits. A carry from high byte 0xFF lands in page 0x00, and operand fetches past 0xFFFF continue at 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (accepted only when idle) |
| mode | input | 2 | bit 1: 0 absolute, 1 zero-page indirect; bit 0 unused naming bit |
| is_store | input | 1 | 1 for a store, 0 for a load |
| index | input | 8 | Index register value |
| wdata | input | 8 | Data to store |
| pc_in | input | 16 | Address of the opcode |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle as `mem_addr` |
| mem_addr | output | 16 | Registered bus address |
| mem_we | output | 1 | Registered write strobe |
| mem_wdata | output | 8 | Registered write data |
| rdata | output | 8 | Data returned by the last load |
| done | output | 1 | One-cycle completion pulse |
| cycles | output | 4 | Bus cycles used by the last sequence |
| pc_out | output | 16 | Program counter after the instruction |

## Verification
The bench builds the block with its default widths: 8-bit data, 16-bit addresses and a 4-bit cycle counter. With these widths the wrap cases can be set up in a few accesses: high byte 0xFF plus carry landing in page zero, the zero-page pointer wrapping from 0xFF to 0x00, and operand fetches running past 0xFFFF. The reference model predicts the full address/strobe trace of every access. Stores with a zero index test the unconditional dummy read, and index values that carry test the corrected second access.

// File: rtl/idx_seq_pkg.sv
package idx_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_OPC   = 3'd1,
    ST_OPND1 = 3'd2,
    ST_OPND2 = 3'd3,
    ST_PTRHI = 3'd4,
    ST_ACC1  = 3'd5,
    ST_ACC2  = 3'd6
  } seq_state_e;

  localparam int MODE_W = 2;

  function automatic logic mode_is_indirect(input logic [MODE_W-1:0] m);
    return m[1];
  endfunction

endpackage

// File: rtl/idx_seq_lo_adder.sv
module idx_seq_lo_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         carry
);
  logic [W:0] c;

  assign c[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]   = a[i] ^ b[i] ^ c[i];
    assign c[i+1]   = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
  end

  assign carry = c[W];
endmodule

// File: rtl/idx_seq_page_fix.sv
module idx_seq_page_fix #(
  parameter int W = 8
) (
  input  logic [W-1:0] hi,
  input  logic         carry,
  output logic [W-1:0] hi_fixed
);
  assign hi_fixed = hi + {{(W-1){1'b0}}, carry};
endmodule

// File: rtl/idx_seq_cycle_cnt.sv
module idx_seq_cycle_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          inc,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] MAX = {CW{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)        count <= '0;
    else if (clear) count <= ONE;
    else if (inc)   count <= count + ONE;
  end

  // R7: the count never wraps within a sequence
  p_cnt_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (inc && !clear) |-> (count != MAX));
endmodule

// File: rtl/idx_seq.sv
module idx_seq
  import idx_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [1:0]            mode,
  input  logic                  is_store,
  input  logic [DATA_W-1:0]     index,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [2*DATA_W-1:0]   pc_in,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic [2*DATA_W-1:0]   mem_addr,
  output logic                  mem_we,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic [DATA_W-1:0]     rdata,
  output logic                  done,
  output logic [CNT_W-1:0]      cycles,
  output logic [2*DATA_W-1:0]   pc_out
);
  localparam int ADDR_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] ONE_B  = DATA_W'(1);
  localparam logic [ADDR_W-1:0] STEP1  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP2  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] STEP3  = ADDR_W'(3);
  localparam logic [DATA_W-1:0] ZPAGE  = '0;

  seq_state_e state;

  logic [ADDR_W-1:0] pc_r;
  logic [DATA_W-1:0] idx_r, wdata_r, lo_r, zp_r, hi_r, sum_r;
  logic              store_r, ind_r, carry_r;

  logic [DATA_W-1:0] sum_w, hi_fix;
  logic              carry_w;
  logic [CNT_W-1:0]  cnt;

  logic accept, take_hi, finish, mode_sel_unused;

  assign mode_sel_unused = mode[0];
  assign accept  = (state == ST_IDLE) && start;
  assign take_hi = ((state == ST_OPND2) && !ind_r) || (state == ST_PTRHI);
  assign finish  = ((state == ST_ACC1) && !store_r && !carry_r) || (state == ST_ACC2);

  idx_seq_lo_adder #(.W(DATA_W)) u_lo_add (
    .a     (lo_r),
    .b     (idx_r),
    .sum   (sum_w),
    .carry (carry_w)
  );

  idx_seq_page_fix #(.W(DATA_W)) u_page_fix (
    .hi       (hi_r),
    .carry    (carry_r),
    .hi_fixed (hi_fix)
  );

  idx_seq_cycle_cnt #(.CW(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clear (accept),
    .inc   ((state != ST_IDLE) && !finish),
    .count (cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pc_r      <= '0;
      idx_r     <= '0;
      wdata_r   <= '0;
      lo_r      <= '0;
      zp_r      <= '0;
      hi_r      <= '0;
      sum_r     <= '0;
      store_r   <= 1'b0;
      ind_r     <= 1'b0;
      carry_r   <= 1'b0;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      rdata     <= '0;
      done      <= 1'b0;
      cycles    <= '0;
      pc_out    <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            pc_r     <= pc_in;
            idx_r    <= index;
            store_r  <= is_store;
            ind_r    <= mode_is_indirect(mode);
            wdata_r  <= wdata;
            mem_addr <= pc_in;
            state    <= ST_OPC;
          end
        end
        ST_OPC: begin
          mem_addr <= pc_r + STEP1;
          state    <= ST_OPND1;
        end
        ST_OPND1: begin
          if (ind_r) begin
            zp_r     <= mem_rdata;
            mem_addr <= {ZPAGE, mem_rdata};
          end else begin
            lo_r     <= mem_rdata;
            mem_addr <= pc_r + STEP2;
          end
          state <= ST_OPND2;
        end
        ST_OPND2: begin
          if (ind_r) begin
            lo_r     <= mem_rdata;
            mem_addr <= {ZPAGE, zp_r + ONE_B};
            state    <= ST_PTRHI;
          end
        end
        ST_ACC1: begin
          if (store_r || carry_r) begin
            mem_addr  <= {hi_fix, sum_r};
            mem_we    <= store_r;
            mem_wdata <= store_r ? wdata_r : mem_wdata;
            state     <= ST_ACC2;
          end else begin
            rdata <= mem_rdata;
          end
        end
        ST_ACC2: begin
          mem_we <= 1'b0;
          if (!store_r) rdata <= mem_rdata;
        end
        default: state <= ST_IDLE;
      endcase

      if (take_hi) begin
        hi_r     <= mem_rdata;
        sum_r    <= sum_w;
        carry_r  <= carry_w;
        mem_addr <= {mem_rdata, sum_w};
        state    <= ST_ACC1;
      end

      if (finish) begin
        done   <= 1'b1;
        cycles <= cnt;
        pc_out <= pc_r + (ind_r ? STEP2 : STEP3);
        state  <= ST_IDLE;
      end
    end
  end

  // R4: a write is preceded by a non-write access in the same low-byte slot
  p_dummy_before_write_r4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (!$past(mem_we) && ($past(mem_addr[DATA_W-1:0]) == mem_addr[DATA_W-1:0])));

  // R3: the second access of a load moves up exactly one page
  p_fix_incr_r3: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_ACC2) && !store_r) |->
      (mem_addr[ADDR_W-1:DATA_W] == $past(mem_addr[ADDR_W-1:DATA_W]) + ONE_B));

  // R5: pointer byte reads stay inside page zero
  p_zp_page_r5: assert property (@(posedge clk) disable iff (rst)
    (ind_r && ((state == ST_OPND2) || (state == ST_PTRHI))) |->
      (mem_addr[ADDR_W-1:DATA_W] == ZPAGE));

  // R7: done is a single-cycle pulse with a legal count
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_cycle_range_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> ((cycles >= CNT_W'(4)) && (cycles <= CNT_W'(6))));

  // R8: captured operands stay put while busy
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
    ((state != ST_IDLE) && (state != ST_OPC)) |-> ($stable(pc_r) && $stable(idx_r)));

  // R9: write strobe only while the store is in its second access
  p_we_only_store_r9: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (store_r && (state == ST_ACC2)));
endmodule

// File: tb/idx_seq_tb_top.sv
module idx_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [1:0]  mode;
  logic        is_store;
  logic [7:0]  index, wdata;
  logic [15:0] pc_in;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata, rdata;
  logic        done;
  logic [3:0]  cycles;
  logic [15:0] pc_out;

  int nchk = 0;
  int nbad = 0;
  int mem_gen = 0;
  logic [7:0] last_rd = 8'h00;
  logic [7:0] mem_q [logic [15:0]];

  always #2 clk = ~clk;

  idx_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .is_store(is_store),
    .index(index), .wdata(wdata), .pc_in(pc_in), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .rdata(rdata), .done(done), .cycles(cycles), .pc_out(pc_out)
  );

  function automatic logic [7:0] rd(input logic [15:0] a);
    if (mem_q.exists(a)) return mem_q[a];
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(mem_addr or mem_gen) mem_rdata = rd(mem_addr);

  always @(posedge clk) begin
    if (mem_we) begin
      mem_q[mem_addr] = mem_wdata;
      mem_gen++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", nchk, nbad);
  endtask

  // Behavioural reference: builds the expected bus trace and compares every cycle
  task automatic run_op(input logic [1:0] md, input bit st, input logic [7:0] ix,
                        input logic [7:0] wd, input logic [15:0] pc,
                        input string req, input bit poke);
    logic [15:0] ta[$];
    bit          tw[$];
    logic [7:0]  b1, lo, hi, exp_rd;
    logic [8:0]  s;
    logic [15:0] part, fin, exp_pc;
    bit          ind;
    ind = md[1];
    b1  = rd(pc + 16'd1);
    if (ind) begin
      lo = rd({8'h00, b1});
      hi = rd({8'h00, b1 + 8'd1});
    end else begin
      lo = b1;
      hi = rd(pc + 16'd2);
    end
    s    = {1'b0, lo} + {1'b0, ix};
    part = {hi, s[7:0]};
    fin  = {hi + {7'd0, s[8]}, s[7:0]};
    ta.push_back(pc);            tw.push_back(1'b0);
    ta.push_back(pc + 16'd1);    tw.push_back(1'b0);
    if (ind) begin
      ta.push_back({8'h00, b1});         tw.push_back(1'b0);
      ta.push_back({8'h00, b1 + 8'd1});  tw.push_back(1'b0);
    end else begin
      ta.push_back(pc + 16'd2);          tw.push_back(1'b0);
    end
    ta.push_back(part); tw.push_back(1'b0);
    if (st || s[8]) begin
      ta.push_back(fin); tw.push_back(st);
    end
    exp_rd = st ? last_rd : rd((st || s[8]) ? fin : part);
    exp_pc = pc + (ind ? 16'd2 : 16'd3);

    @(negedge clk);
    start = 1'b1; mode = md; is_store = st; index = ix; wdata = wd; pc_in = pc;
    for (int k = 0; k < ta.size(); k++) begin
      @(negedge clk);
      start = 1'b0;
      if (poke && k == 1) begin
        start = 1'b1; mode = ~md; is_store = ~st; index = ix + 8'h33;
        wdata = ~wd; pc_in = pc + 16'h0100;
      end
      chk(mem_addr == ta[k], req, $sformatf("addr cycle %0d", k), mem_addr, ta[k]);
      chk(mem_we == tw[k], (tw[k] || st) ? "R9" : req,
          $sformatf("we cycle %0d", k), mem_we, tw[k]);
      if (tw[k]) chk(mem_wdata == wd, "R9", "write data", mem_wdata, wd);
      chk(done == 1'b0, req, "done early", done, 0);
    end
    start = 1'b0;
    @(negedge clk);
    chk(done == 1'b1, "R7", "done pulse", done, 1);
    chk(cycles == 4'(ta.size()), req, "cycle count", cycles, ta.size());
    chk(pc_out == exp_pc, "R7", "pc_out", pc_out, exp_pc);
    chk(rdata == exp_rd, st ? "R4" : req, "rdata", rdata, exp_rd);
    last_rd = exp_rd;
    @(negedge clk);
    chk(done == 1'b0, "R7", "done width", done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; mode = 2'b00; is_store = 1'b0;
    index = 8'h00; wdata = 8'h00; pc_in = 16'h0000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(done == 1'b0,       "R1", "done",   done, 0);
    chk(mem_we == 1'b0,     "R1", "we",     mem_we, 0);
    chk(cycles == 4'd0,     "R1", "cycles", cycles, 0);
    chk(rdata == 8'h00,     "R1", "rdata",  rdata, 0);
    chk(mem_addr == 16'h0,  "R1", "addr",   mem_addr, 0);
    chk(pc_out == 16'h0,    "R1", "pc_out", pc_out, 0);

    // R2 absolute load, no carry
    mem_q[16'h0201] = 8'h40; mem_q[16'h0202] = 8'h12; mem_q[16'h1245] = 8'hA7;
    run_op(2'b00, 1'b0, 8'h05, 8'h00, 16'h0200, "R2", 1'b0);
    run_op(2'b00, 1'b0, 8'h00, 8'h00, 16'h0200, "R2", 1'b0);
    // R3 absolute load with carry
    mem_q[16'h0301] = 8'hF0; mem_q[16'h0302] = 8'h20;
    run_op(2'b01, 1'b0, 8'h20, 8'h00, 16'h0300, "R3", 1'b0);
    // R6 mode bit 0 has no effect
    run_op(2'b00, 1'b0, 8'h20, 8'h00, 16'h0300, "R6", 1'b0);
    // R4 store, zero index still takes the extra cycle
    mem_q[16'h0401] = 8'h33; mem_q[16'h0402] = 8'h06;
    run_op(2'b00, 1'b1, 8'h00, 8'hC3, 16'h0400, "R4", 1'b0);
    run_op(2'b00, 1'b0, 8'h00, 8'h00, 16'h0400, "R4", 1'b0);
    // R4 store with carry
    run_op(2'b01, 1'b1, 8'hE0, 8'h5E, 16'h0400, "R4", 1'b0);
    run_op(2'b01, 1'b0, 8'hE0, 8'h00, 16'h0400, "R4", 1'b0);
    // R5 indirect load, no carry / carry / store
    mem_q[16'h0501] = 8'h80; mem_q[16'h0080] = 8'h10; mem_q[16'h0081] = 8'h34;
    run_op(2'b10, 1'b0, 8'h04, 8'h00, 16'h0500, "R5", 1'b0);
    run_op(2'b10, 1'b0, 8'hF8, 8'h00, 16'h0500, "R5", 1'b0);
    run_op(2'b10, 1'b1, 8'h01, 8'h9A, 16'h0500, "R5", 1'b0);
    // R6 mode 11 behaves as indirect
    run_op(2'b11, 1'b0, 8'h04, 8'h00, 16'h0500, "R6", 1'b0);
    // R5 pointer wrap in page zero
    mem_q[16'h0601] = 8'hFF; mem_q[16'h00FF] = 8'h22; mem_q[16'h0000] = 8'h07;
    run_op(2'b10, 1'b0, 8'h01, 8'h00, 16'h0600, "R5", 1'b0);
    // R10 high byte wrap and PC wrap
    mem_q[16'h0701] = 8'hC0; mem_q[16'h0702] = 8'hFF;
    run_op(2'b00, 1'b0, 8'h50, 8'h00, 16'h0700, "R10", 1'b0);
    run_op(2'b00, 1'b1, 8'h50, 8'h6D, 16'h0700, "R10", 1'b0);
    run_op(2'b00, 1'b0, 8'h02, 8'h00, 16'hFFFE, "R10", 1'b0);
    // R8 start during a running sequence is ignored
    run_op(2'b01, 1'b0, 8'h20, 8'h00, 16'h0300, "R8", 1'b1);
    run_op(2'b10, 1'b1, 8'h04, 8'h11, 16'h0500, "R8", 1'b1);

    summary();
    $finish;
  end
endmodule